// File: doc/BRIEF.md
# Tick-Driven Compare Timer

This block is an up-counter that advances on an external tick enable, nominally pulsing at 16 MHz. A power-of-two divider sits between the tick and the counter. The counter wraps at one of four selectable widths. Four compare channels watch it. Each channel owns a sticky event flag. The flag latches when the counter steps onto a value equal to that channel's compare register. It stays set until software writes zero to it.

Software reaches the block through a plain register bus. A write to a task address starts, stops or clears the counter. Other addresses read or clear the event flags and set the width, divider and compare values. Read data is registered.

The event flags and the live count are also driven out as plain status pins, so neighbouring logic can watch them without using the bus. No data stream passes through the block, so it has no valid/ready interface and applies no back-pressure. Every bus access is accepted in the cycle it is presented.

Top module: `tick_compare_timer`

## Requirements
- R1: After reset the count is 0, all event flags are 0, the counter is stopped, the width select is 0 (16-bit), the divider exponent is 0 and every compare register is 0.
- R2: An event flag goes to 1 on a match and stays 1 until a bus write of value 0 to its event address (word 4 + channel). Writing a nonzero value leaves the flag unchanged. When a match and a zeroing write land on the same edge, the flag ends at 1.
- R3: A write with bit 0 set to word 0 starts counting and to word 1 stops it. The same kind of write to word 2 sets the count and the divider phase to 0, and it takes priority over a step on the same edge. While stopped, the count holds.
- R4: The counter steps once every 2^P ticks, where P is the divider exponent written to word 9 in bits 3:0. Values above 9 are stored as 9.
- R5: Word 8 bits 1:0 select the width: 0 is 16-bit, 1 is 8-bit, 2 is 24-bit, 3 is 32-bit. The counter goes from the all-ones value of the selected width to 0.
- R6: A channel matches when a step takes the count to a value equal to its compare register (words 12 to 15), masked to the selected width. A compare value the count has already passed only matches after the next wrap.
- R7: No flag is set while the counter is stopped, even if the held count equals a compare value.
- R8: Compare values, width, divider and event flags can be rewritten while the counter runs, and the next step uses the new values.
- R9: A read presented on one edge shows its data on bus_rdata_o after that edge, and the data holds until the next read. Word 10 returns the count, word 8 the width, word 9 the divider exponent, and words 4 to 7 and 12 to 15 the flags and compare values. All other words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Counting tick enable (one pulse per tick) |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| count_o | output | 32 | Current count |
| evt_o | output | 4 | Event flags, bit n = channel n |

## Verification
Two situations are hardest to reach from the ports.

The first is a zeroing write that lands on the same edge as a match. The bench clears the counter with no divider and starts it. It then counts the exact edges since the start write, so that the event write arrives on the edge where the count steps onto the compare value.

The second is the 16-bit wrap. It needs more than 65 thousand steps, so the tick is held high every cycle. The flag is zeroed after its first match, and the bench checks that the flag is set again only after the wrap.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  parameter int CH      = 4;   // compare channels
  parameter int CW      = 32;  // counter width (widest mode)
  parameter int DW      = 32;  // bus data width
  parameter int AW      = 5;   // bus word address width
  parameter int PSW     = 4;   // divider exponent register width
  parameter int PSC_MAX = 9;   // largest divider exponent
  localparam int PW     = PSC_MAX; // divider phase counter width

  localparam logic [AW-1:0] A_START = AW'(0);
  localparam logic [AW-1:0] A_STOP  = AW'(1);
  localparam logic [AW-1:0] A_CLEAR = AW'(2);
  localparam logic [AW-1:0] A_EVT0  = AW'(4);
  localparam logic [AW-1:0] A_MODE  = AW'(8);
  localparam logic [AW-1:0] A_PSC   = AW'(9);
  localparam logic [AW-1:0] A_COUNT = AW'(10);
  localparam logic [AW-1:0] A_CMP0  = AW'(12);

  typedef enum logic [1:0] {
    WID_16 = 2'd0,
    WID_8  = 2'd1,
    WID_24 = 2'd2,
    WID_32 = 2'd3
  } width_e;

  function automatic logic [CW-1:0] width_mask(width_e w);
    case (w)
      WID_8:   width_mask = CW'(32'h0000_00FF);
      WID_24:  width_mask = CW'(32'h00FF_FFFF);
      WID_32:  width_mask = CW'(32'hFFFF_FFFF);
      default: width_mask = CW'(32'h0000_FFFF);
    endcase
  endfunction
endpackage

// File: rtl/tt_regs.sv
module tt_regs
  import tick_timer_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_i,
  input  logic                   wr_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [CW-1:0]          count_i,
  input  logic [CH-1:0]          flags_i,
  output logic                   start_o,
  output logic                   stop_o,
  output logic                   clear_o,
  output logic [CH-1:0]          evt_clr_o,
  output width_e                 mode_o,
  output logic [PSW-1:0]         psc_o,
  output logic [CH-1:0][CW-1:0]  cmp_o,
  output logic [DW-1:0]          rdata_o
);
  logic wr_en, rd_en;
  logic [PSW-1:0] psc_wr;
  logic [DW-1:0]  rd_mux;

  assign wr_en = sel_i & wr_i;
  assign rd_en = sel_i & ~wr_i;

  assign start_o = wr_en & wdata_i[0] & (addr_i == A_START);
  assign stop_o  = wr_en & wdata_i[0] & (addr_i == A_STOP);
  assign clear_o = wr_en & wdata_i[0] & (addr_i == A_CLEAR);

  assign psc_wr = (wdata_i[PSW-1:0] > PSW'(PSC_MAX)) ? PSW'(PSC_MAX) : wdata_i[PSW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o <= WID_16;
      psc_o  <= '0;
    end else if (wr_en) begin
      if (addr_i == A_MODE) mode_o <= width_e'(wdata_i[1:0]);
      if (addr_i == A_PSC)  psc_o  <= psc_wr;
    end
  end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    localparam logic [AW-1:0] EA = A_EVT0 + AW'(i);
    localparam logic [AW-1:0] CA = A_CMP0 + AW'(i);
    assign evt_clr_o[i] = wr_en & (addr_i == EA) & (wdata_i == '0);
    always_ff @(posedge clk) begin
      if (!rst_n)                        cmp_o[i] <= '0;
      else if (wr_en && addr_i == CA)    cmp_o[i] <= wdata_i[CW-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_MODE)  rd_mux = DW'(mode_o);
    if (addr_i == A_PSC)   rd_mux = DW'(psc_o);
    if (addr_i == A_COUNT) rd_mux = DW'(count_i);
    for (int i = 0; i < CH; i++) begin
      if (addr_i == A_EVT0 + AW'(i)) rd_mux = DW'(flags_i[i]);
      if (addr_i == A_CMP0 + AW'(i)) rd_mux = DW'(cmp_o[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_mux;
  end

  AST_PSC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    psc_o <= PSW'(PSC_MAX)); // R4
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_o)); // R9
endmodule

// File: rtl/tt_prescale.sv
module tt_prescale
  import tick_timer_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic           tick_i,
  input  logic           clear_i,
  input  logic [PSW-1:0] psc_i,
  output logic           step_o
);
  logic [PW-1:0] phase_q;
  logic [PW-1:0] low;

  assign low    = ~({PW{1'b1}} << psc_i);
  assign step_o = run_i & tick_i & ((phase_q & low) == low);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i)  phase_q <= '0;
    else if (run_i && tick_i) phase_q <= phase_q + PW'(1);
  end

  AST_PHASE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i && !clear_i |=> $stable(phase_q)); // R3
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tick_timer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          clear_i,
  input  logic          step_i,
  input  width_e        mode_i,
  output logic          run_o,
  output logic          adv_o,
  output logic [CW-1:0] mask_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] count_nxt_o
);
  assign mask_o      = width_mask(mode_i);
  assign count_nxt_o = (count_o + CW'(1)) & mask_o;
  assign adv_o       = step_i & ~clear_i;

  always_ff @(posedge clk) begin
    if (!rst_n)       run_o <= 1'b0;
    else if (start_i) run_o <= 1'b1;
    else if (stop_i)  run_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) count_o <= '0;
    else if (step_i)       count_o <= count_nxt_o;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> count_o == '0); // R3
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o && !clear_i |=> $stable(count_o)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o && count_o == mask_o |=> count_o == '0); // R5
endmodule

// File: rtl/tt_channel.sv
module tt_channel
  import tick_timer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic [CW-1:0] count_nxt_i,
  input  logic [CW-1:0] mask_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          clr_i,
  output logic          flag_o
);
  logic hit;
  assign hit = adv_i & (count_nxt_i == (cmp_i & mask_i));

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (hit)   flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !clr_i |=> flag_o); // R2
  AST_NO_EVT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> !$rose(flag_o)); // R7
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer
  import tick_timer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          bus_sel_i,
  input  logic          bus_wr_i,
  input  logic [4:0]    bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  output logic [31:0]   count_o,
  output logic [3:0]    evt_o
);
  logic start, stop, clear, step, run, adv;
  logic [CH-1:0] evt_clr, flags;
  width_e mode;
  logic [PSW-1:0] psc;
  logic [CH-1:0][CW-1:0] cmp;
  logic [CW-1:0] mask, count, count_nxt;

  tt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sel_i(bus_sel_i), .wr_i(bus_wr_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .count_i(count),
    .flags_i(flags), .start_o(start), .stop_o(stop), .clear_o(clear),
    .evt_clr_o(evt_clr), .mode_o(mode), .psc_o(psc), .cmp_o(cmp),
    .rdata_o(bus_rdata_o));

  tt_prescale u_psc (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick_i),
    .clear_i(clear), .psc_i(psc), .step_o(step));

  tt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
    .clear_i(clear), .step_i(step), .mode_i(mode), .run_o(run),
    .adv_o(adv), .mask_o(mask), .count_o(count), .count_nxt_o(count_nxt));

  for (genvar i = 0; i < CH; i++) begin : g_chan
    tt_channel u_ch (
      .clk(clk), .rst_n(rst_n), .adv_i(adv), .count_nxt_i(count_nxt),
      .mask_i(mask), .cmp_i(cmp[i]), .clr_i(evt_clr[i]), .flag_o(flags[i]));
  end

  assign count_o = count;
  assign evt_o   = flags;

  AST_MATCH_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> !$rose(evt_o)); // R6
endmodule

// File: tb/tick_compare_timer_test.sv
module tick_compare_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b1;
  logic bus_sel_i = 1'b0, bus_wr_i = 1'b0;
  logic [4:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o, count_o;
  logic [3:0] evt_o;

  int checks = 0, errors = 0, cycles = 0, tick_div = 1, tcnt = 0;

  // behavioural reference state
  longint m_cnt, m_rd, m_cmp[4];
  int m_pre, m_mode, m_psc;
  bit m_run;
  bit [3:0] m_ev;

  always #2.5 clk = ~clk;

  tick_compare_timer uut (.*);

  function automatic longint mmask(int md);
    case (md)
      1: return 64'hFF;
      2: return 64'hFF_FFFF;
      3: return 64'hFFFF_FFFF;
      default: return 64'hFFFF;
    endcase
  endfunction

  always @(negedge clk) begin
    tcnt++;
    tick_i = ((tcnt % tick_div) == 0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rd = 0; m_pre = 0; m_mode = 0; m_psc = 0; m_run = 0; m_ev = 0;
      for (int i = 0; i < 4; i++) m_cmp[i] = 0;
    end else begin
      longint mk, nx;
      int a, lw;
      bit st, clr;
      bit [3:0] hit;
      a = bus_addr_i;
      mk = mmask(m_mode);
      lw = (1 << m_psc) - 1;
      clr = bus_sel_i && bus_wr_i && bus_wdata_i[0] && a == 2;
      st = m_run && tick_i && ((m_pre & lw) == lw);
      nx = (m_cnt + 1) & mk;
      hit = 0;
      if (st && !clr) for (int i = 0; i < 4; i++) if (nx == (m_cmp[i] & mk)) hit[i] = 1;
      if (bus_sel_i && !bus_wr_i) begin
        m_rd = 0;
        if (a == 8) m_rd = m_mode;
        if (a == 9) m_rd = m_psc;
        if (a == 10) m_rd = m_cnt;
        if (a >= 4 && a <= 7) m_rd = m_ev[a-4];
        if (a >= 12 && a <= 15) m_rd = m_cmp[a-12];
      end
      for (int i = 0; i < 4; i++) begin
        if (hit[i]) m_ev[i] = 1;
        else if (bus_sel_i && bus_wr_i && a == 4 + i && bus_wdata_i == 0) m_ev[i] = 0;
      end
      if (clr) m_pre = 0; else if (m_run && tick_i) m_pre = (m_pre + 1) % 512;
      if (clr) m_cnt = 0; else if (st) m_cnt = nx;
      if (bus_sel_i && bus_wr_i) begin
        if (a == 0 && bus_wdata_i[0]) m_run = 1;
        if (a == 1 && bus_wdata_i[0]) m_run = 0;
        if (a == 8) m_mode = bus_wdata_i[1:0];
        if (a == 9) m_psc = (bus_wdata_i[3:0] > 9) ? 9 : bus_wdata_i[3:0];
        if (a >= 12 && a <= 15) m_cmp[a-12] = bus_wdata_i;
      end
    end
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R3 model count", count_o, m_cnt);
      check("R2 model events", evt_o, m_ev);
      check("R9 model rdata", bus_rdata_o, m_rd);
    end
    if (cycles > 190000) begin
      checks++; errors++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cycles, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(int a, longint d);
    @(negedge clk);
    bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = 5'(a); bus_wdata_i = 32'(d);
    @(negedge clk);
    bus_sel_i = 0; bus_wr_i = 0;
  endtask

  task automatic rd(int a, output longint d);
    @(negedge clk);
    bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = 5'(a);
    @(negedge clk);
    bus_sel_i = 0;
    d = bus_rdata_o;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    longint v, held;
    idle(3);
    rst_n = 1;
    // R1 reset state
    rd(10, v); check("R1 count", v, 0);
    check("R1 events", evt_o, 0);
    rd(8, v);  check("R1 width", v, 0);
    rd(9, v);  check("R1 divider", v, 0);
    rd(12, v); check("R1 compare", v, 0);

    // R6 / R8: 8-bit mode, matches and passed compare value
    wr(8, 1); wr(12, 2); wr(13, 100); wr(14, 200); wr(15, 250);
    wr(0, 1);
    idle(50);
    check("R6 first match only", evt_o, 4'b0001);
    wr(13, 10);
    idle(30);
    check("R8 passed value not yet matched", evt_o[1], 0);
    idle(200);
    check("R6 passed value matches after wrap", evt_o[1], 1);

    // R2 write nonzero keeps flag, zero clears
    wr(4, 1);  check("R2 nonzero write ignored", evt_o[0], 1);
    wr(4, 0);  check("R2 zero write clears", evt_o[0], 0);

    // R5 exact 8-bit wrap
    wr(1, 1); wr(2, 1); wr(0, 1);
    idle(256);
    check("R5 8-bit wrap to zero", count_o, 0);
    idle(1);
    check("R5 after wrap", count_o, 1);

    // R3 / R7 stop holds, no events while stopped
    wr(1, 1);
    held = count_o;
    wr(4, 0); wr(12, held);
    idle(20);
    check("R3 stopped count holds", count_o, held);
    check("R7 no event while stopped", evt_o[0], 0);
    wr(2, 1);
    check("R3 clear task", count_o, 0);
    wr(15, 0); wr(7, 0); idle(10);
    check("R7 equal while stopped no event", evt_o[3], 0);

    // R4 divider clamp and rate
    wr(9, 15); rd(9, v); check("R4 divider clamp", v, 9);
    wr(9, 2); wr(2, 1); wr(0, 1);
    idle(40);
    check("R4 one step per four ticks", count_o, 10);

    // R2 same-edge match and zeroing write
    wr(1, 1); wr(9, 0); wr(8, 1); wr(2, 1); wr(12, 3); wr(4, 0);
    wr(0, 1);
    idle(1);
    wr(4, 0);
    check("R2 match wins over clearing write", evt_o[0], 1);

    // R5 / R6 16-bit wrap with compare 5
    wr(1, 1); wr(8, 0); wr(15, 5); wr(2, 1); wr(0, 1);
    idle(100);
    wr(7, 0);
    check("R2 flag cleared before wrap", evt_o[3], 0);
    idle(65536 - 102 + 10);
    check("R5 16-bit wrap count", count_o, 10);
    check("R6 match after 16-bit wrap", evt_o[3], 1);

    // R5 24-bit passes 8 bits, tick gaps
    wr(1, 1); wr(8, 2); wr(2, 1); wr(0, 1);
    idle(300);
    check("R5 24-bit no early wrap", count_o, 300);
    tick_div = 3;
    wr(8, 3);
    idle(60);
    rd(10, v); check("R9 count read", v, m_rd);
    rd(8, v);  check("R9 width read", v, 3);
    rd(3, v);  check("R9 unused word", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule